// File: doc/BRIEF.md
# Cache write-allocate decision unit

This unit decides, for every memory write that misses the cache, whether a cache line should be allocated for it. It combines a set of general cache-enable conditions with three allocation mechanisms. The enable conditions are a global cache-disable bit, a per-cycle page cache-disable signal, a test-mode cache-inhibit bit and the memory-type attribute from the range registers. The mechanisms are an address limit, a match against the page of the most recent cacheable read miss, and a match against the sector tags of resident lines. The decision is the enable conditions ANDed with the OR of the three mechanisms.

The limit mechanism never qualifies a write in the legacy 640 KB to 1 MB window. It qualifies a write in the 15 to 16 MB hole only when a separate hole-enable bit is set. Writes in either region can still allocate through the page or sector mechanisms. The page register and the sector tag table are filled from read-miss feedback. Each write request produces a registered decision with a valid strobe one clock later.

Top module: `wr_alloc_decider`

## Requirements
- R1: While `glob_cd` is 1, a write request yields `dec_alloc` = 0.
- R2: When `page_cd` is 1 in the cycle of a write request, that request yields `dec_alloc` = 0.
- R3: While `test_ci` is 1, a write request yields `dec_alloc` = 0.
- R4: `mem_type` encodes 2'b00 write-back, 2'b01 write-through, 2'b10 uncacheable and 2'b11 write-combining. Either of the last two forces `dec_alloc` = 0 whatever the mechanisms say. The first two allow allocation.
- R5: `alloc_limit` is in 4 MB units. A write with address bits [31:22] below `alloc_limit` qualifies through the limit mechanism. A value of zero disables that mechanism.
- R6: Addresses 0x000A_0000 to 0x000F_FFFF never qualify through the limit mechanism.
- R7: Addresses 0x00F0_0000 to 0x00FF_FFFF qualify through the limit mechanism only when `hole_en` is 1 and `alloc_limit` is 4 or more.
- R8: When `alloc_limit` is below 4 (under 16 MB), `hole_en` has no effect on any decision.
- R9: A fill pulse with `fill_addr` loads address bits [31:12] into the page register. A later write whose bits [31:12] equal it qualifies through the page mechanism, including in the regions of R6 and R7. Only the most recent fill page is held.
- R10: Each fill pulse also writes tag `fill_addr[31:6]` into an 8-entry table, round-robin from entry 0. A write whose bits [31:6] match any valid entry qualifies through the sector mechanism. The ninth fill overwrites the first tag.
- R11: `dec_valid` is 1 exactly in the cycle after a cycle with `wr_req` = 1. `dec_alloc` is 0 whenever `dec_valid` is 0. Table updates from a fill become visible to writes from the next cycle on.
- R12: After reset, `dec_valid` and `dec_alloc` are 0 and both the page register and the sector table are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Write-miss request strobe |
| wr_addr | input | 32 | Write byte address |
| glob_cd | input | 1 | Global cache-disable bit |
| page_cd | input | 1 | Page cache-disable for this cycle |
| test_ci | input | 1 | Test-register cache-inhibit bit |
| mem_type | input | 2 | Range-register memory type |
| alloc_limit | input | 7 | Allocation limit, 4 MB units |
| hole_en | input | 1 | Allow limit allocation in the 15-16 MB hole |
| fill_vld | input | 1 | Cacheable read-miss fill pulse |
| fill_addr | input | 32 | Address of the filled line |
| dec_valid | output | 1 | Decision strobe |
| dec_alloc | output | 1 | 1 = allocate a line for the write |

## Verification
A corrupted page register or sector tag table can only show up as a wrong `dec_alloc` on a write whose limit result does not already decide the outcome. The bench therefore runs its history tests with the limit mechanism at zero, and there any fault appears on the decision one cycle after the write. A lost round-robin pointer appears only after the table wraps. For that reason the bench makes nine fills and probes every sector, including the evicted one. The limit and exclusion logic is swept over every limit value from 0 to 8, both hole settings and addresses on each side of every region edge.

// File: rtl/wa_pkg.sv
// Package: shared constants and types for the write-allocate decision unit.
// Assumes a 32-bit byte address space; region bounds are absolute addresses.
package wa_pkg;
    typedef enum logic [1:0] {
        MT_WB = 2'b00,
        MT_WT = 2'b01,
        MT_UC = 2'b10,
        MT_WC = 2'b11
    } mem_type_e;

    localparam logic [31:0] LEGACY_LO = 32'h000A_0000;
    localparam logic [31:0] LEGACY_HI = 32'h000F_FFFF;
    localparam logic [11:0] HOLE_MB   = 12'h00F;  // address bits [31:20] of the 15-16 MB hole
endpackage

// File: rtl/wa_limit_check.sv
// Module: address-limit mechanism. Purely combinational.
// Qualifies a write below the programmed limit, excluding the legacy window
// and (unless enabled with a limit of at least 16 MB) the 15-16 MB hole.
module wa_limit_check #(
    parameter int ADDR_W      = 32,
    parameter int LIMIT_W     = 7,
    parameter int LIMIT_SHIFT = 22
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [LIMIT_W-1:0] limit,
    input  logic               hole_en,
    output logic               lim_ok,
    output logic               in_legacy,
    output logic               in_hole
);
    localparam int REGION_W = ADDR_W - LIMIT_SHIFT;
    localparam int HOLE_MIN = 16 >> (LIMIT_SHIFT - 20);  // 16 MB in limit units

    logic [REGION_W-1:0] region;
    logic                below;
    logic                hole_allowed;

    // Compare the address region against the limit and apply the exclusions.
    always_comb begin
        region       = addr[ADDR_W-1:LIMIT_SHIFT];
        below        = (limit != '0) && (region < REGION_W'(limit));
        in_legacy    = (addr >= wa_pkg::LEGACY_LO) && (addr <= wa_pkg::LEGACY_HI);
        in_hole      = (addr[ADDR_W-1:20] == wa_pkg::HOLE_MB);
        hole_allowed = hole_en && (limit >= LIMIT_W'(HOLE_MIN));
        lim_ok       = below && !in_legacy && !(in_hole && !hole_allowed);
    end
endmodule

// File: rtl/wa_page_reg.sv
// Module: cacheable-page history. Holds the page number of the latest
// cacheable read-miss fill and flags writes to the same page.
module wa_page_reg #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_vld,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              page_hit
);
    localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

    logic              pg_vld_q;
    logic [PAGE_W-1:0] pg_q;

    // Capture the page of each fill; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_vld_q <= 1'b0;
            pg_q     <= '0;
        end else if (fill_vld) begin
            pg_vld_q <= 1'b1;
            pg_q     <= fill_addr[ADDR_W-1:PAGE_SHIFT];
        end
    end

    // Match the write page against the held page.
    always_comb page_hit = pg_vld_q && (pg_q == wr_addr[ADDR_W-1:PAGE_SHIFT]);

    assert_page_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_vld |=> pg_vld_q && (pg_q == $past(fill_addr[ADDR_W-1:PAGE_SHIFT])));
endmodule

// File: rtl/wa_sector_table.sv
// Module: resident-sector tag table, filled round-robin on each fill.
// Assumes ENTRIES is a power of two so the pointer wraps naturally.
module wa_sector_table #(
    parameter int ADDR_W     = 32,
    parameter int SECT_SHIFT = 6,
    parameter int ENTRIES    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_vld,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              sect_hit
);
    localparam int TAG_W = ADDR_W - SECT_SHIFT;
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] match;
    logic [PTR_W-1:0]   ptr_q;

    // Advance the replacement pointer on each fill.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else if (fill_vld) ptr_q <= ptr_q + 1'b1;
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        // Load this entry when the pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
            end else if (fill_vld && (ptr_q == PTR_W'(i))) begin
                vld_q[i] <= 1'b1;
                tag_q[i] <= fill_addr[ADDR_W-1:SECT_SHIFT];
            end
        end
        // Compare this entry against the write tag.
        always_comb match[i] = vld_q[i] && (tag_q[i] == wr_addr[ADDR_W-1:SECT_SHIFT]);
    end

    // Any valid match satisfies the sector mechanism.
    always_comb sect_hit = |match;

    assert_sector_written_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_vld |=> vld_q[$past(ptr_q)] && (tag_q[$past(ptr_q)] == $past(fill_addr[ADDR_W-1:SECT_SHIFT])));
endmodule

// File: rtl/wr_alloc_decider.sv
// Module: top of the write-allocate decision unit. Combines the general
// cache-enable conditions with the limit, page and sector mechanisms and
// registers the result one cycle after the write request.
module wr_alloc_decider #(
    parameter int ADDR_W       = 32,
    parameter int LIMIT_W      = 7,
    parameter int LIMIT_SHIFT  = 22,
    parameter int PAGE_SHIFT   = 12,
    parameter int SECT_SHIFT   = 6,
    parameter int SECT_ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic               glob_cd,
    input  logic               page_cd,
    input  logic               test_ci,
    input  logic [1:0]         mem_type,
    input  logic [LIMIT_W-1:0] alloc_limit,
    input  logic               hole_en,
    input  logic               fill_vld,
    input  logic [ADDR_W-1:0]  fill_addr,
    output logic               dec_valid,
    output logic               dec_alloc
);
    import wa_pkg::*;

    logic lim_ok, in_legacy, in_hole, page_hit, sect_hit;
    logic gen_ok, alloc_d;

    wa_limit_check #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .LIMIT_SHIFT(LIMIT_SHIFT)) u_limit (
        .addr(wr_addr), .limit(alloc_limit), .hole_en(hole_en),
        .lim_ok(lim_ok), .in_legacy(in_legacy), .in_hole(in_hole)
    );

    wa_page_reg #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_page (
        .clk(clk), .rst_n(rst_n), .fill_vld(fill_vld), .fill_addr(fill_addr),
        .wr_addr(wr_addr), .page_hit(page_hit)
    );

    wa_sector_table #(.ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT), .ENTRIES(SECT_ENTRIES)) u_sect (
        .clk(clk), .rst_n(rst_n), .fill_vld(fill_vld), .fill_addr(fill_addr),
        .wr_addr(wr_addr), .sect_hit(sect_hit)
    );

    // General enable gate ANDed with the OR of the three mechanisms.
    always_comb begin
        gen_ok  = !glob_cd && !page_cd && !test_ci &&
                  (mem_type != MT_UC) && (mem_type != MT_WC);
        alloc_d = gen_ok && (lim_ok || page_hit || sect_hit);
    end

    // Register the decision and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_alloc <= 1'b0;
        end else begin
            dec_valid <= wr_req;
            dec_alloc <= wr_req && alloc_d;
        end
    end

    assert_glob_cd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && glob_cd) |=> !dec_alloc);
    assert_page_cd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && page_cd) |=> !dec_alloc);
    assert_test_ci_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && test_ci) |=> !dec_alloc);
    assert_memtype_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && mem_type[1]) |=> !dec_alloc);
    assert_legacy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_legacy |-> !lim_ok);
    assert_hole_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hole && !hole_en) |-> !lim_ok);
    assert_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> dec_valid);
    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> (!dec_valid && !dec_alloc));
endmodule

// File: tb/wr_alloc_decider_tb.sv
`timescale 1ns/1ps
module wr_alloc_decider_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0;
    logic [31:0] wr_addr = '0;
    logic        glob_cd = 1'b0, page_cd = 1'b0, test_ci = 1'b0, hole_en = 1'b0;
    logic [1:0]  mem_type = 2'b00;
    logic [6:0]  alloc_limit = '0;
    logic        fill_vld = 1'b0;
    logic [31:0] fill_addr = '0;
    logic        dec_valid, dec_alloc;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // Bench-side history model, kept from the requirements.
    bit          m_pg_vld = 1'b0;
    logic [19:0] m_pg = '0;
    bit          m_tv [8];
    logic [25:0] m_tag [8];
    int          m_ptr = 0;

    logic [31:0] pts [20] = '{32'h0, 32'h0009_FFFF, 32'h000A_0000, 32'h000F_FFFF,
        32'h0010_0000, 32'h00EF_FFFF, 32'h00F0_0000, 32'h00FF_FFFF, 32'h0100_0000,
        32'h003F_FFFF, 32'h0040_0000, 32'h007F_FFFF, 32'h0080_0000, 32'h00BF_FFFF,
        32'h00C0_0000, 32'h013F_FFFF, 32'h0140_0000, 32'h01FF_FFFF, 32'h0200_0000,
        32'hFFFF_FFFF};

    always #2.5 clk = ~clk;

    wr_alloc_decider u_dut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
        .glob_cd(glob_cd), .page_cd(page_cd), .test_ci(test_ci), .mem_type(mem_type),
        .alloc_limit(alloc_limit), .hole_en(hole_en), .fill_vld(fill_vld),
        .fill_addr(fill_addr), .dec_valid(dec_valid), .dec_alloc(dec_alloc)
    );

    function automatic bit expect_alloc(input logic [31:0] a);
        bit gen, lim, pg, sec;
        gen = !glob_cd && !page_cd && !test_ci && !mem_type[1];
        lim = (alloc_limit != 0) && ({22'd0, a[31:22]} < {25'd0, alloc_limit})
              && !(a >= 32'h000A_0000 && a <= 32'h000F_FFFF)
              && !(a[31:20] == 12'h00F && !(hole_en && alloc_limit >= 4));
        pg  = m_pg_vld && (m_pg == a[31:12]);
        sec = 1'b0;
        for (int i = 0; i < 8; i++) if (m_tv[i] && m_tag[i] == a[31:6]) sec = 1'b1;
        return gen && (lim || pg || sec);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h actual=%b expected=%b", req, wr_addr, act, exp);
        end
    endtask

    // One write request; decision checked in the following cycle.
    task automatic write(input logic [31:0] a, input string req);
        bit e;
        @(negedge clk);
        wr_addr = a; wr_req = 1'b1;
        e = expect_alloc(a);
        @(negedge clk);
        wr_req = 1'b0;
        check({req, " valid"}, dec_valid, 1'b1);
        check(req, dec_alloc, e);
    endtask

    task automatic fill(input logic [31:0] a);
        @(negedge clk);
        fill_addr = a; fill_vld = 1'b1;
        @(negedge clk);
        fill_vld = 1'b0;
        m_pg_vld = 1'b1; m_pg = a[31:12];
        m_tv[m_ptr] = 1'b1; m_tag[m_ptr] = a[31:6];
        m_ptr = (m_ptr + 1) % 8;
    endtask

    initial begin
        #(5 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_tv[i] = 1'b0; m_tag[i] = '0; end
        repeat (3) @(negedge clk);
        check("R12 reset valid", dec_valid, 1'b0);
        check("R12 reset alloc", dec_alloc, 1'b0);
        rst_n = 1'b1;

        // R12: empty history, limit off -> nothing allocates.
        alloc_limit = 0;
        for (int p = 0; p < 20; p++) write(pts[p], "R12 empty");

        // R5 R6 R7 R8: limit sweep over limits, hole setting, region edges.
        for (int l = 0; l <= 8; l++)
            for (int h = 0; h < 2; h++)
                for (int p = 0; p < 20; p++) begin
                    alloc_limit = 7'(l); hole_en = h[0];
                    write(pts[p], (l < 4) ? "R8 limit" : "R5 R6 R7 limit");
                end

        // R1 R2 R3 R4: gating sweep with limit satisfied.
        alloc_limit = 8; hole_en = 1'b1;
        for (int g = 0; g < 32; g++) begin
            glob_cd = g[0]; page_cd = g[1]; test_ci = g[2]; mem_type = g[4:3];
            write(32'h0000_1000, "R1 R2 R3 R4 gate");
            write(32'h0050_0040, "R1 R2 R3 R4 gate");
        end
        glob_cd = 0; page_cd = 0; test_ci = 0; mem_type = 2'b00;

        // R11: idle cycle after a decision drops the strobe.
        @(negedge clk);
        check("R11 idle valid", dec_valid, 1'b0);
        check("R11 idle alloc", dec_alloc, 1'b0);

        // R9: page mechanism, including excluded regions.
        alloc_limit = 0;
        fill(32'h000B_2340);
        write(32'h000B_2FFC, "R9 page legacy");
        write(32'h000B_3000, "R9 page miss");
        fill(32'h00F4_5000);
        write(32'h00F4_5800, "R9 page hole");
        write(32'h000B_2FFC, "R9 page replaced");

        // R10: nine fills in distinct pages; first sector evicted.
        for (int k = 0; k < 9; k++) fill(32'h0200_0000 + k * 32'h0001_0000 + 32'h80);
        for (int k = 0; k < 9; k++) begin
            write(32'h0200_0000 + k * 32'h0001_0000 + 32'h80, "R10 sector");
            write(32'h0200_0000 + k * 32'h0001_0000 + 32'hC0, "R10 sector neighbour");
        end
        mem_type = 2'b11;
        write(32'h0203_0080, "R4 sector suppressed");
        mem_type = 2'b01;
        write(32'h0203_0080, "R4 write-through");
        mem_type = 2'b00;

        // R11: fill and write in the same cycle sees the old table.
        @(negedge clk);
        fill_addr = 32'h0300_0000; fill_vld = 1'b1;
        wr_addr = 32'h0300_0000; wr_req = 1'b1;
        @(negedge clk);
        fill_vld = 1'b0; wr_req = 1'b0;
        check("R11 same-cycle fill", dec_alloc, 1'b0);
        m_pg_vld = 1'b1; m_pg = 20'h03000;
        m_tv[m_ptr] = 1'b1; m_tag[m_ptr] = 26'(32'h0300_0000 >> 6); m_ptr = (m_ptr + 1) % 8;
        write(32'h0300_0000, "R11 next-cycle fill");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule